// File: doc/BRIEF.md
# Vectored Interrupt Response Sequencer

This block runs the table-indirect interrupt acknowledge of an 8-bit processor core. When interrupts are enabled and a request is pending, it runs one fixed sequence. It first asserts an acknowledge strobe so that the interrupting device can present a vector byte. It then pushes the current program counter onto a descending stack. Next it reads a two-byte service address from a table in memory, and finally loads that address into the program counter.

The table pointer is 16 bits wide. The high byte comes from a page register input. The low byte is the device byte with its least significant bit forced to zero, so every table entry sits at an even address. The table is held in ordinary read/write memory, so software can rewrite entries between interrupts and give each device its own handler. The block owns the program counter and stack pointer registers, and the rest of the core may load them while the sequencer is idle.

Top module: `vec_irq_seq`

## Requirements
- R1: The table pointer is {page_in, vec_in[7:1], 0}. An odd vector byte selects the same entry as the even byte below it.
- R2: The service address is formed from two reads: the byte at the pointer is the low half and the byte at pointer+1 is the high half. The program counter ends equal to {high, low}.
- R3: The old program counter is pushed with two writes. The high byte goes to SP-1 first and the low byte to SP-2 second. The stack pointer ends 2 below its starting value, modulo 2^16.
- R4: From the first acknowledge cycle to the last cycle of the sequence takes exactly 19 cycles. `done` is high for exactly one cycle, the cycle right after the last one, which is the first cycle in which `pc_q` shows the service address.
- R5: `irq_ack` is high for exactly the first 7 cycles of the sequence and low at all other times. The vector byte is taken from `vec_in` in the 7th of those cycles only.
- R6: `ie_flag` is set by a one-cycle `ie_set` pulse and clears when a sequence starts. No sequence starts while `ie_flag` is low.
- R7: A one-cycle `irq_req` pulse is remembered until a sequence starts. A request raised while a sequence is running starts the next sequence in the cycle that `done` is high, provided `ie_flag` has been set again.
- R8: `pc_ld` and `sp_ld` load `pc_q` and `sp_q` on the next edge when the sequencer is idle. They are ignored while `busy` is high.
- R9: After reset, `pc_q` = 0, `sp_q` = 0, and `ie_flag`, `busy`, `done`, `irq_ack`, `mem_we` and `mem_re` are all low.
- R10: The service address is read from memory during each sequence. Changing a table entry between two interrupts changes the address that is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ie_set | input | 1 | One-cycle pulse that enables interrupt acceptance |
| irq_req | input | 1 | Interrupt request pulse (remembered) |
| irq_ack | output | 1 | Acknowledge strobe to the device during the vector phase |
| vec_in | input | 8 | Vector byte from the interrupting device |
| page_in | input | 8 | Interrupt page register value (pointer high byte) |
| pc_ld | input | 1 | Load program counter from pc_ld_val (idle only) |
| pc_ld_val | input | 16 | Program counter load value |
| sp_ld | input | 1 | Load stack pointer from sp_ld_val (idle only) |
| sp_ld_val | input | 16 | Stack pointer load value |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| ie_flag | output | 1 | Interrupt enable flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the service address is in pc_q |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe (write on clock edge) |
| mem_re | output | 1 | Memory read strobe (data sampled same cycle) |
| mem_rdata | input | 8 | Memory read data (combinational response) |

## Verification
The bench builds the block with its default parameters. These are an 8-bit data path, which gives a 16-bit pointer, and phase lengths of 7, 6 and 6 cycles. With these values the exact 19-cycle count and the 7-cycle acknowledge window can be checked cycle by cycle. The vector byte is driven to its real value only in the 7th acknowledge cycle, so any change in when it is sampled shows up in the loaded address. The 16-bit stack and pointer let a table entry at page 0x12 and a stack near 0x8000 coexist in a small model memory. Both odd and even vector bytes are applied, and a second request is raised in the middle of a running sequence.

// File: rtl/vis_pkg.sv
package vis_pkg;

  // Sequencer phases: idle, device acknowledge, stack save, table fetch.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACK   = 2'd1,
    PH_SAVE  = 2'd2,
    PH_FETCH = 2'd3
  } phase_e;

endpackage

// File: rtl/vis_timer.sv
module vis_timer
  import vis_pkg::*;
#(
  parameter int ACK_CYC   = 7,
  parameter int SAVE_CYC  = 6,
  parameter int FETCH_CYC = 6,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] ACK_END   = CNT_W'(ACK_CYC - 1);
  localparam logic [CNT_W-1:0] SAVE_END  = CNT_W'(SAVE_CYC - 1);
  localparam logic [CNT_W-1:0] FETCH_END = CNT_W'(FETCH_CYC - 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    unique case (phase)
      PH_ACK:   last = (cnt == ACK_END);
      PH_SAVE:  last = (cnt == SAVE_END);
      PH_FETCH: last = (cnt == FETCH_END);
      default:  last = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ACK;
          cnt_d   = '0;
        end
      end
      PH_ACK: begin
        if (last) begin
          phase_d = PH_SAVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + CNT_W'(1);
        end
      end
      PH_SAVE: begin
        if (last) begin
          phase_d = PH_FETCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + CNT_W'(1);
        end
      end
      default: begin
        if (last) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
    end
  end

  // The acknowledge phase always lasts its full length before the save phase.
  assert_ack_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAVE && $past(phase) == PH_ACK) |-> ($past(cnt) == ACK_END));

  // The fetch phase is entered only from a completed save phase.
  assert_fetch_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH && $past(phase) != PH_FETCH) |-> ($past(phase) == PH_SAVE && $past(cnt) == SAVE_END));

endmodule

// File: rtl/vis_ptr.sv
module vis_ptr #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] vec_in,
  input  logic [DATA_W-1:0] page_in,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [DATA_W-1:0] EVEN_MASK = ~DATA_W'(1);

  logic [DATA_W-1:0] vec_q, vec_d;
  logic [DATA_W-1:0] page_q, page_d;

  always_comb begin
    vec_d  = vec_q;
    page_d = page_q;
    if (capture) begin
      vec_d  = vec_in & EVEN_MASK;
      page_d = page_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      page_q <= '0;
    end else begin
      vec_q  <= vec_d;
      page_q <= page_d;
    end
  end

  assign ptr = {page_q, vec_q};

endmodule

// File: rtl/vis_regs.sv
module vis_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              pc_ld,
  input  logic [ADDR_W-1:0] pc_ld_val,
  input  logic              sp_ld,
  input  logic [ADDR_W-1:0] sp_ld_val,
  input  logic              svc_ld,
  input  logic [ADDR_W-1:0] svc_val,
  input  logic              sp_dec,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] sp_q
);

  localparam logic [ADDR_W-1:0] PUSH_SZ = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_d, sp_d;

  always_comb begin
    pc_d = pc_q;
    sp_d = sp_q;
    if (svc_ld) begin
      pc_d = svc_val;
    end else if (pc_ld && !busy) begin
      pc_d = pc_ld_val;
    end
    if (sp_dec) begin
      sp_d = sp_q - PUSH_SZ;
    end else if (sp_ld && !busy) begin
      sp_d = sp_ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      pc_q <= pc_d;
      sp_q <= sp_d;
    end
  end

endmodule

// File: rtl/vec_irq_seq.sv
module vec_irq_seq
  import vis_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ACK_CYC   = 7,
  parameter int SAVE_CYC  = 6,
  parameter int FETCH_CYC = 6,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_set,
  input  logic              irq_req,
  output logic              irq_ack,
  input  logic [DATA_W-1:0] vec_in,
  input  logic [DATA_W-1:0] page_in,
  input  logic              pc_ld,
  input  logic [ADDR_W-1:0] pc_ld_val,
  input  logic              sp_ld,
  input  logic [ADDR_W-1:0] sp_ld_val,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic              ie_flag,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int MAX_AS  = (ACK_CYC > SAVE_CYC) ? ACK_CYC : SAVE_CYC;
  localparam int MAX_CYC = (MAX_AS > FETCH_CYC) ? MAX_AS : FETCH_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  // Bus slots inside the save and fetch phases (both phases need >= 4 cycles).
  localparam logic [CNT_W-1:0] SLOT_HI = CNT_W'(1);
  localparam logic [CNT_W-1:0] SLOT_LO = CNT_W'(3);
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             start;
  logic             ie_q, ie_d;
  logic             pend_q, pend_d;
  logic             done_q, done_d;
  logic [DATA_W-1:0] svc_lo_q, svc_lo_d;
  logic [DATA_W-1:0] svc_hi_q, svc_hi_d;
  logic [ADDR_W-1:0] ptr;
  logic             vec_cap;
  logic             svc_ld;
  logic             sp_dec;
  logic             in_save, in_fetch;

  assign busy     = (phase != PH_IDLE);
  assign start    = !busy && ie_q && (pend_q || irq_req);
  assign irq_ack  = (phase == PH_ACK);
  assign vec_cap  = irq_ack && last;
  assign in_save  = (phase == PH_SAVE);
  assign in_fetch = (phase == PH_FETCH);
  assign sp_dec   = in_save && last;
  assign svc_ld   = in_fetch && last;

  vis_timer #(
    .ACK_CYC  (ACK_CYC),
    .SAVE_CYC (SAVE_CYC),
    .FETCH_CYC(FETCH_CYC),
    .CNT_W    (CNT_W)
  ) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .phase(phase),
    .cnt  (cnt),
    .last (last)
  );

  vis_ptr #(
    .DATA_W(DATA_W)
  ) i_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(vec_cap),
    .vec_in (vec_in),
    .page_in(page_in),
    .ptr    (ptr)
  );

  vis_regs #(
    .ADDR_W(ADDR_W)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .pc_ld    (pc_ld),
    .pc_ld_val(pc_ld_val),
    .sp_ld    (sp_ld),
    .sp_ld_val(sp_ld_val),
    .svc_ld   (svc_ld),
    .svc_val  ({svc_hi_q, svc_lo_q}),
    .sp_dec   (sp_dec),
    .pc_q     (pc_q),
    .sp_q     (sp_q)
  );

  // Memory port: two stack writes, then two table reads.
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    if (in_save && cnt == SLOT_HI) begin
      mem_we    = 1'b1;
      mem_addr  = sp_q - ONE;
      mem_wdata = pc_q[ADDR_W-1:DATA_W];
    end else if (in_save && cnt == SLOT_LO) begin
      mem_we    = 1'b1;
      mem_addr  = sp_q - TWO;
      mem_wdata = pc_q[DATA_W-1:0];
    end else if (in_fetch && cnt == SLOT_HI) begin
      mem_re   = 1'b1;
      mem_addr = ptr;
    end else if (in_fetch && cnt == SLOT_LO) begin
      mem_re   = 1'b1;
      mem_addr = ptr | ONE;
    end
  end

  always_comb begin
    svc_lo_d = svc_lo_q;
    svc_hi_d = svc_hi_q;
    if (in_fetch && cnt == SLOT_HI) svc_lo_d = mem_rdata;
    if (in_fetch && cnt == SLOT_LO) svc_hi_d = mem_rdata;
  end

  always_comb begin
    ie_d = ie_q;
    if (start)       ie_d = 1'b0;
    else if (ie_set) ie_d = 1'b1;
    pend_d = (pend_q || irq_req) && !start;
    done_d = svc_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      svc_lo_q <= '0;
      svc_hi_q <= '0;
    end else begin
      ie_q     <= ie_d;
      pend_q   <= pend_d;
      done_q   <= done_d;
      svc_lo_q <= svc_lo_d;
      svc_hi_q <= svc_hi_d;
    end
  end

  assign ie_flag = ie_q;
  assign done    = done_q;

  assert_start_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ie_flag));

  assert_ie_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ie_flag);

  assert_ack_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_push_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp_q - ONE || mem_addr == sp_q - TWO));

  assert_bus_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pc_q) || done));

endmodule

// File: tb/test_vec_irq_seq.sv
module test_vec_irq_seq;

  logic        clk;
  logic        rst_n;
  logic        ie_set;
  logic        irq_req;
  logic        irq_ack;
  logic [7:0]  vec_in;
  logic [7:0]  page_in;
  logic        pc_ld;
  logic [15:0] pc_ld_val;
  logic        sp_ld;
  logic [15:0] sp_ld_val;
  logic [15:0] pc_q;
  logic [15:0] sp_q;
  logic        ie_flag;
  logic        busy;
  logic        done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;

  int checks;
  int fails;

  logic [7:0]  mem [0:1023];
  logic [15:0] wr_log [0:15];
  int          wr_total;

  vec_irq_seq i_vec_irq_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ie_set   (ie_set),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .vec_in   (vec_in),
    .page_in  (page_in),
    .pc_ld    (pc_ld),
    .pc_ld_val(pc_ld_val),
    .sp_ld    (sp_ld),
    .sp_ld_val(sp_ld_val),
    .pc_q     (pc_q),
    .sp_q     (sp_q),
    .ie_flag  (ie_flag),
    .busy     (busy),
    .done     (done),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      mem[mem_addr[9:0]]       <= mem_wdata;
      wr_log[wr_total[3:0]]    <= mem_addr;
      wr_total                 <= wr_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Enable interrupts with a one-cycle pulse.
  task automatic enable_irq();
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); ie_set = 1'b0;
  endtask

  // Follows one sequence whose start cycle is the current one.
  // inject: 0 none, 1 new request + enable mid-sequence, 2 pc/sp loads mid-sequence.
  task automatic watch_seq(input logic [15:0] exp_pc, input logic [15:0] sp0,
                           input logic [15:0] pc0, input logic [7:0] vec,
                           input int inject, input string tag);
    int base;
    int ack_bad;
    int done_bad;
    logic [15:0] a_hi;
    logic [15:0] a_lo;
    base = wr_total;
    ack_bad = 0;
    done_bad = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      irq_req = 1'b0;
      ie_set  = 1'b0;
      pc_ld   = 1'b0;
      sp_ld   = 1'b0;
      vec_in  = (n == 7) ? vec : ~vec;
      if (n == 10 && inject == 1) begin
        irq_req = 1'b1;
        ie_set  = 1'b1;
      end
      if (n == 10 && inject == 2) begin
        pc_ld = 1'b1; pc_ld_val = 16'hDEAD;
        sp_ld = 1'b1; sp_ld_val = 16'h0100;
      end
      if (irq_ack !== (n <= 7)) ack_bad++;
      if (busy !== (n <= 19)) ack_bad++;
      if (done !== (n == 20)) done_bad++;
    end
    chk(ack_bad == 0, "R5", {tag, " ack/busy window"}, ack_bad, 0);
    chk(done_bad == 0, "R4", {tag, " 19-cycle span and done pulse"}, done_bad, 0);
    chk(pc_q == exp_pc, "R2", {tag, " service address in pc"}, pc_q, exp_pc);
    chk(sp_q == sp0 - 16'd2, "R3", {tag, " sp after push"}, sp_q, sp0 - 16'd2);
    a_hi = sp0 - 16'd1;
    a_lo = sp0 - 16'd2;
    chk(mem[a_hi[9:0]] == pc0[15:8], "R3", {tag, " pushed high byte"}, mem[a_hi[9:0]], pc0[15:8]);
    chk(mem[a_lo[9:0]] == pc0[7:0], "R3", {tag, " pushed low byte"}, mem[a_lo[9:0]], pc0[7:0]);
    chk(wr_total == base + 2, "R3", {tag, " write count"}, wr_total - base, 2);
    chk(wr_log[base[3:0]] == a_hi && wr_log[4'(base + 1)] == a_lo, "R3",
        {tag, " push order"}, wr_log[base[3:0]], a_hi);
    if (inject == 0) chk(ie_flag == 1'b0, "R6", {tag, " enable cleared"}, ie_flag, 0);
  endtask

  task automatic set_regs(input logic [15:0] pc, input logic [15:0] sp);
    @(negedge clk);
    pc_ld = 1'b1; pc_ld_val = pc;
    sp_ld = 1'b1; sp_ld_val = sp;
    @(negedge clk);
    pc_ld = 1'b0; sp_ld = 1'b0;
    chk(pc_q == pc && sp_q == sp, "R8", "idle load of pc/sp", pc_q, pc);
  endtask

  task automatic fire_irq();
    @(negedge clk);
    irq_req = 1'b1;
  endtask

  task automatic t_reset();
    chk(pc_q == 16'h0 && sp_q == 16'h0, "R9", "pc/sp reset", pc_q, 0);
    chk({ie_flag, busy, done, irq_ack, mem_we, mem_re} == 6'b0, "R9", "control reset",
        {ie_flag, busy, done, irq_ack, mem_we, mem_re}, 0);
  endtask

  task automatic t_basic();
    mem[10'h234] = 8'hCD; mem[10'h235] = 8'hAB;
    page_in = 8'h12;
    set_regs(16'h5A3C, 16'h8000);
    enable_irq();
    fire_irq();
    watch_seq(16'hABCD, 16'h8000, 16'h5A3C, 8'h34, 0, "R1 even vector");
  endtask

  task automatic t_odd_vec();
    set_regs(16'h1111, 16'h8000);
    enable_irq();
    fire_irq();
    watch_seq(16'hABCD, 16'h8000, 16'h1111, 8'h35, 0, "R1 odd vector");
  endtask

  task automatic t_table_change();
    mem[10'h234] = 8'h02; mem[10'h235] = 8'h40;
    set_regs(16'h2222, 16'h8000);
    enable_irq();
    fire_irq();
    watch_seq(16'h4002, 16'h8000, 16'h2222, 8'h34, 0, "R10 rewritten entry");
  endtask

  task automatic t_no_enable();
    int bad;
    bad = 0;
    mem[10'h280] = 8'h77; mem[10'h281] = 8'h66;
    set_regs(16'h3333, 16'h8000);
    @(negedge clk); irq_req = 1'b1;
    for (int n = 0; n < 25; n++) begin
      @(negedge clk);
      irq_req = 1'b0;
      if (busy !== 1'b0 || irq_ack !== 1'b0) bad++;
    end
    chk(bad == 0, "R6", "no start with enable low", bad, 0);
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); ie_set = 1'b0;
    watch_seq(16'h6677, 16'h8000, 16'h3333, 8'h80, 0, "R7 held request");
  endtask

  task automatic t_busy_request();
    set_regs(16'h4444, 16'h8000);
    enable_irq();
    fire_irq();
    watch_seq(16'h6677, 16'h8000, 16'h4444, 8'h81, 1, "R7 first");
    watch_seq(16'h4002, 16'h7FFE, 16'h6677, 8'h34, 0, "R7 back-to-back");
  endtask

  task automatic t_busy_loads();
    set_regs(16'h5555, 16'h8000);
    enable_irq();
    fire_irq();
    watch_seq(16'h6677, 16'h8000, 16'h5555, 8'h80, 2, "R8 loads while busy");
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; wr_total = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) wr_log[i] = 16'h0;
    rst_n = 1'b0;
    ie_set = 1'b0; irq_req = 1'b0; vec_in = 8'h00; page_in = 8'h00;
    pc_ld = 1'b0; pc_ld_val = 16'h0; sp_ld = 1'b0; sp_ld_val = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_odd_vec();
    t_table_change();
    t_no_enable();
    t_busy_request();
    t_busy_loads();
    summary();
    $finish;
  end

endmodule